// File: doc/BRIEF.md
# Dual-Channel Shadowed Pulse-Width Modulator

This block generates two independent pulse-width modulated outputs from one system clock. Each channel owns four word registers (control, clock divider, cycle length and compare level), reached through a simple single-cycle register port: a write is taken on the clock edge where `reg_wr` is high, and `reg_rdata` always shows the register picked by `reg_addr` in the same cycle. Every write first lands in a shadow copy, and a shared status word shows which shadow values are still waiting to reach the counting logic.

Software programs the divider, the cycle length and the compare level, then sets the enable bit. Each channel divides the clock by (divider+1), counts from zero up to the cycle length, and drives its output high while the count is below the compare level, optionally inverted. With the autoload bit set, new timing values wait for the end of the running cycle so that no period is ever cut short or stretched. Software polls the status word until the bit it cares about reads zero before writing that register again.

Top module: `pwm_dual_shadow`

## Requirements
- R1: Channel c's registers sit at byte address 16c plus 0 (control), 4 (divider, 10 bits), 8 (cycle length, 12 bits) and 12 (compare level, 12 bits); address bits 1:0 are ignored. Reads return the last written value masked to its width, control reads bits 3:0 only. Addresses 0x20 to 0x3F and the status word at 0x40 ignore writes, and 0x20 to 0x3F read as zero.
- R2: The status word at 0x40 gives channel c four pending flags at bit 8c: +0 control, +1 divider, +2 cycle length, +3 compare level. A flag reads 1 from the edge that takes the write; every other status bit reads 0.
- R3: A control write becomes active on the edge after the write edge; its pending flag reads 1 for exactly one cycle.
- R4: With autoload (control bit 2) clear, a divider, cycle-length or compare write becomes active on the edge after the write edge and its flag clears then.
- R5: With autoload set on a running channel, a divider, cycle-length or compare write stays pending, flag set, until the edge that ends the current output period; on an idle channel it commits on the next edge.
- R6: Control bit 4 forces a pending divider commit, and bit 5 forces pending cycle-length and compare commits, on the edge where that control value becomes active, whatever autoload says. Neither bit is stored.
- R7: A running channel repeats a period of (P+1)(N+1) clocks for divider P and cycle length N, high for (P+1)·min(D, N+1) clocks at compare level D; D=0 gives a constant low and D>N a constant high.
- R8: Control bit 1 inverts the output; a stopped channel drives the value of bit 1.
- R9: Clearing the enable bit (control bit 0) with bit 3 clear lets the current period run to its end before the channel stops.
- R10: Clearing the enable bit with bit 3 set drives the idle level from the second edge after the write edge.
- R11: The two channels count and commit independently; writes to one never alter the other's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| reg_wr | input | 1 | Register write strobe, taken on the rising edge |
| reg_addr | input | 7 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| pwm_out | output | 2 | One modulated output per channel |

## Verification
The immediate-stop check assumes software does not rewrite the same channel's control register in the cycle after a stop request; the bench always spaces control writes by at least two cycles. The pending-flag checks take for granted that `reg_wr` and `reg_addr` are steady around the rising edge, so the bench changes them only on falling edges. Waveform checks lock onto a rising output edge before timing a period, since the counter phase is not visible at the ports.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;

  // Register selector inside one channel's 16-byte slot (address bits 3:2).
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DIV  = 2'd1,
    SEL_LEN  = 2'd2,
    SEL_CMP  = 2'd3
  } reg_sel_e;

  // Stored control bits; the two load strobes (bits 5:4) are kept apart.
  typedef struct packed {
    logic stop_now;
    logic autoload;
    logic invert;
    logic enable;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int LOAD_W = 2;

endpackage

// File: rtl/pwm_shadow_reg.sv
// One software-visible register with a shadow copy, an active copy and a
// pending flag. commit_ok lets a pending value move; force_ld overrides it.
module pwm_shadow_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         commit_ok,
  input  logic         force_ld,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active,
  output logic         pending
);

  logic do_commit;
  assign do_commit = pending && (commit_ok || force_ld);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow  <= '0;
      active  <= '0;
      pending <= 1'b0;
    end else begin
      if (wr)        shadow <= wdata;
      if (do_commit) active <= shadow;
      // A new write re-arms the flag even on a commit edge.
      if (wr)             pending <= 1'b1;
      else if (do_commit) pending <= 1'b0;
    end
  end

endmodule

// File: rtl/pwm_chan_core.sv
// Divider, period counter, run state and output shaping for one channel.
module pwm_chan_core #(
  parameter int DIV_W = 10,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             invert,
  input  logic             stop_now,
  input  logic [DIV_W-1:0] div_val,
  input  logic [LEN_W-1:0] len_val,
  input  logic [LEN_W-1:0] cmp_val,
  output logic             running,
  output logic             wrap,
  output logic             wave
);

  logic [DIV_W-1:0] pre_q;
  logic [LEN_W-1:0] cnt_q;
  logic             run_q;
  logic             run_d;
  logic             pre_end;

  // >= keeps the counters bounded when a smaller limit commits mid-count.
  assign pre_end = (pre_q >= div_val);
  assign wrap    = run_q && pre_end && (cnt_q >= len_val);
  assign run_d   = enable || (run_q && !stop_now && !wrap);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      if (!run_q || !run_d) begin
        pre_q <= '0;
        cnt_q <= '0;
      end else if (pre_end) begin
        pre_q <= '0;
        cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign running = run_q;
  assign wave    = (run_q && (cnt_q < cmp_val)) ^ invert;

endmodule

// File: rtl/pwm_chan.sv
// One channel: four shadowed registers, commit policy, readback, core.
module pwm_chan
  import pwm_dual_pkg::*;
#(
  parameter int DIV_W  = 10,
  parameter int LEN_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          wr_sel,
  input  logic [DATA_W-1:0] wdata,
  input  reg_sel_e          rd_sel,
  output logic [DATA_W-1:0] rd_word,
  output logic [3:0]        pend,
  output logic              wave
);

  logic [CTRL_W-1:0] ctrl_sh_raw, ctrl_act_raw;
  logic [DIV_W-1:0]  div_sh, div_act;
  logic [LEN_W-1:0]  len_sh, len_act, cmp_sh, cmp_act;
  logic              ctrl_p, div_p, len_p, cmp_p;
  logic [LOAD_W-1:0] load_q;
  ctrl_t             ctrl_act;
  logic              running, wrap, data_ok;
  logic              force_div, force_len;
  logic              unused_wdata;

  assign ctrl_act     = ctrl_t'(ctrl_act_raw);
  assign unused_wdata = ^wdata[DATA_W-1:LEN_W];

  // Load strobes travel with their control write and act at its commit.
  always_ff @(posedge clk) begin
    if (!rst_n)                            load_q <= '0;
    else if (wr_en && wr_sel == SEL_CTRL)  load_q <= wdata[CTRL_W +: LOAD_W];
  end

  assign force_div = ctrl_p && load_q[0];
  assign force_len = ctrl_p && load_q[1];
  assign data_ok   = !ctrl_act.autoload || !running || wrap;

  pwm_shadow_reg #(.W(CTRL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(wr_en && wr_sel == SEL_CTRL),
    .wdata(wdata[CTRL_W-1:0]), .commit_ok(1'b1), .force_ld(1'b0),
    .shadow(ctrl_sh_raw), .active(ctrl_act_raw), .pending(ctrl_p));

  pwm_shadow_reg #(.W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .wr(wr_en && wr_sel == SEL_DIV),
    .wdata(wdata[DIV_W-1:0]), .commit_ok(data_ok), .force_ld(force_div),
    .shadow(div_sh), .active(div_act), .pending(div_p));

  pwm_shadow_reg #(.W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .wr(wr_en && wr_sel == SEL_LEN),
    .wdata(wdata[LEN_W-1:0]), .commit_ok(data_ok), .force_ld(force_len),
    .shadow(len_sh), .active(len_act), .pending(len_p));

  pwm_shadow_reg #(.W(LEN_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wr(wr_en && wr_sel == SEL_CMP),
    .wdata(wdata[LEN_W-1:0]), .commit_ok(data_ok), .force_ld(force_len),
    .shadow(cmp_sh), .active(cmp_act), .pending(cmp_p));

  pwm_chan_core #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .enable(ctrl_act.enable), .invert(ctrl_act.invert), .stop_now(ctrl_act.stop_now),
    .div_val(div_act), .len_val(len_act), .cmp_val(cmp_act),
    .running(running), .wrap(wrap), .wave(wave));

  assign pend = {cmp_p, len_p, div_p, ctrl_p};

  always_comb begin
    unique case (rd_sel)
      SEL_CTRL: rd_word = {{(DATA_W-CTRL_W){1'b0}}, ctrl_sh_raw};
      SEL_DIV:  rd_word = {{(DATA_W-DIV_W){1'b0}}, div_sh};
      SEL_LEN:  rd_word = {{(DATA_W-LEN_W){1'b0}}, len_sh};
      default:  rd_word = {{(DATA_W-LEN_W){1'b0}}, cmp_sh};
    endcase
  end

endmodule

// File: rtl/pwm_dual_shadow.sv
module pwm_dual_shadow
  import pwm_dual_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int SLOT_CNT = 4,
  parameter int DIV_W    = 10,
  parameter int LEN_W    = 12,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  localparam int SLOT_LSB = 4;
  localparam int SEL_LSB  = 2;
  localparam int IDX_W    = $clog2(SLOT_CNT);
  localparam int GRP_W    = 8;
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(SLOT_CNT << SLOT_LSB);

  logic              slot_hit;
  logic [IDX_W-1:0]  slot;
  reg_sel_e          sel;
  logic [DATA_W-1:0] rd_v [NUM_CH];
  logic [3:0]        pend_v [NUM_CH];
  logic [DATA_W-1:0] status_word;
  logic              unused_addr;

  assign slot_hit    = (reg_addr < STAT_ADDR);
  assign slot        = reg_addr[SLOT_LSB +: IDX_W];
  assign sel         = reg_sel_e'(reg_addr[SEL_LSB +: 2]);
  assign unused_addr = ^reg_addr[SEL_LSB-1:0];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    pwm_chan #(.DIV_W(DIV_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr && slot_hit && slot == IDX_W'(ch)),
      .wr_sel(sel), .wdata(reg_wdata), .rd_sel(sel),
      .rd_word(rd_v[ch]), .pend(pend_v[ch]), .wave(pwm_out[ch]));
  end

  always_comb begin
    status_word = '0;
    for (int c = 0; c < NUM_CH; c++) status_word[c*GRP_W +: 4] = pend_v[c];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == STAT_ADDR) reg_rdata = status_word;
    else if (slot_hit)
      for (int c = 0; c < NUM_CH; c++)
        if (slot == IDX_W'(c)) reg_rdata = rd_v[c];
  end

endmodule

// File: rtl/pwm_dual_shadow_chk.sv
module pwm_dual_shadow_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [6:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [1:0]  pwm_out,
  input logic [31:0] status_word
);

  logic unused_chk;
  assign unused_chk = ^{reg_wdata[31:4], reg_wdata[2], pwm_out[1]};

  AST_LEN_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 7'h08) |=> status_word[2]);  // R2

  AST_CTRL_FLAG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[0] && !(reg_wr && reg_addr == 7'h00)) |=> !status_word[0]);  // R3

  AST_STATUS_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word & 32'hFFFF_F0F0) == 32'h0);  // R2

  AST_STOP_NOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_wr && reg_addr == 7'h00 && !reg_wdata[0] && reg_wdata[3], 3) &&
     !$past(reg_wr && reg_addr == 7'h00, 2))
    |-> pwm_out[0] == $past(reg_wdata[1], 3));  // R10

endmodule

bind pwm_dual_shadow pwm_dual_shadow_chk u_chk (.*);

// File: tb/pwm_dual_shadow_bench.sv
module pwm_dual_shadow_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  pwm_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pwm_dual_shadow u_pwm_dual_shadow (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic sync_rise(input int ch);
    logic prev;
    prev = pwm_out[ch];
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!prev && pwm_out[ch]) return;
      prev = pwm_out[ch];
    end
  endtask

  task automatic measure(input int ch, output int hi, output int per);
    logic prev;
    sync_rise(ch);
    hi = 0; per = 0;
    for (int i = 0; i < 20000; i++) begin
      hi += int'(pwm_out[ch]);
      per++;
      prev = pwm_out[ch];
      @(negedge clk);
      if (!prev && pwm_out[ch]) break;
    end
  endtask

  task automatic window(input int ch, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hi += int'(pwm_out[ch]);
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(7'h40, v); chk("R2 status after reset", v, 32'h0);
    rd(7'h00, v); chk("R1 control after reset", v, 32'h0);
    chk("R8 outputs idle low after reset", {30'h0, pwm_out}, 32'h0);
  endtask

  task automatic t_ctrl_flag;
    logic [31:0] v;
    tick();
    wr(7'h00, 32'h2);
    rd(7'h40, v); chk("R3 control flag set", v, 32'h1);
    tick();
    rd(7'h40, v); chk("R3 control flag cleared", v, 32'h0);
    chk("R8 inverted idle level", {31'h0, pwm_out[0]}, 32'h1);
    wr(7'h00, 32'h0); tick(2);
  endtask

  task automatic t_direct_commit;
    logic [31:0] v;
    wr(7'h04, 32'hFFFF_FFFF);
    rd(7'h40, v); chk("R4 divider flag set", v, 32'h2);
    tick();
    rd(7'h40, v); chk("R4 divider flag cleared", v, 32'h0);
    rd(7'h04, v); chk("R1 divider masked readback", v, 32'h3FF);
    tick(); wr(7'h08, 32'hFFFF_FFFF);
    rd(7'h08, v); chk("R1 length masked readback", v, 32'hFFF);
    tick(); wr(7'h04, 32'd1); wr(7'h08, 32'd4); wr(7'h0C, 32'd2); tick(2);
  endtask

  task automatic t_waveform;
    int hi, per;
    wr(7'h00, 32'h1); tick(3);
    measure(0, hi, per);
    chk("R7 period 10", 32'(per), 32'd10);
    chk("R7 high 4", 32'(hi), 32'd4);
    wr(7'h00, 32'h3); tick(3);
    measure(0, hi, per);
    chk("R8 inverted high 6", 32'(hi), 32'd6);
    wr(7'h00, 32'h1); tick(2);
    wr(7'h0C, 32'd0); tick(3);
    window(0, 30, hi); chk("R7 compare zero always low", 32'(hi), 32'd0);
    wr(7'h0C, 32'd4095); tick(3);
    window(0, 30, hi); chk("R7 compare above length always high", 32'(hi), 32'd30);
  endtask

  task automatic t_autoload;
    logic [31:0] v;
    int hi, per;
    wr(7'h04, 32'd0); wr(7'h08, 32'd99); wr(7'h0C, 32'd10); tick(2);
    wr(7'h00, 32'h5); tick(3);
    sync_rise(0);
    wr(7'h0C, 32'd50);
    rd(7'h40, v); chk("R5 compare pending", v, 32'h8);
    tick(20);
    rd(7'h40, v); chk("R5 compare held mid-period", v, 32'h8);
    tick(100);
    rd(7'h40, v); chk("R5 compare committed at period end", v, 32'h0);
    measure(0, hi, per);
    chk("R5 new compare high 50", 32'(hi), 32'd50);
  endtask

  task automatic t_force_load;
    logic [31:0] v;
    int hi, per;
    sync_rise(0);
    wr(7'h08, 32'd49); wr(7'h0C, 32'd20);
    rd(7'h40, v); chk("R5 length and compare pending", v, 32'hC);
    wr(7'h00, 32'h25);
    rd(7'h40, v); chk("R6 flags before forced load", v, 32'hD);
    tick();
    rd(7'h40, v); chk("R6 forced load cleared flags", v, 32'h0);
    rd(7'h00, v); chk("R6 load bit not stored", v, 32'h5);
    measure(0, hi, per);
    chk("R6 forced period 50", 32'(per), 32'd50);
    chk("R6 forced high 20", 32'(hi), 32'd20);
  endtask

  task automatic t_graceful;
    int hi;
    wr(7'h00, 32'h1); tick(2);
    wr(7'h04, 32'd0); wr(7'h08, 32'd9); wr(7'h0C, 32'd5); tick(3);
    sync_rise(0);
    wr(7'h00, 32'h0); tick(2);
    chk("R9 period continues after disable", {31'h0, pwm_out[0]}, 32'h1);
    tick(20);
    window(0, 20, hi); chk("R9 stopped after period", 32'(hi), 32'd0);
  endtask

  task automatic t_stop_now;
    wr(7'h00, 32'h1); tick(3);
    sync_rise(0);
    wr(7'h00, 32'h8); tick(2);
    chk("R10 immediate stop low", {31'h0, pwm_out[0]}, 32'h0);
    wr(7'h00, 32'hA); tick(3);
    chk("R8 stopped inverted idle high", {31'h0, pwm_out[0]}, 32'h1);
    wr(7'h00, 32'h1); tick(3);
  endtask

  task automatic t_second_channel;
    logic [31:0] v;
    int hi, per;
    wr(7'h14, 32'd0);
    rd(7'h40, v); chk("R2 channel 1 divider flag at bit 9", v, 32'h200);
    wr(7'h18, 32'd7); wr(7'h1C, 32'd3); wr(7'h10, 32'h1); tick(3);
    measure(1, hi, per);
    chk("R11 channel 1 period 8", 32'(per), 32'd8);
    chk("R11 channel 1 high 3", 32'(hi), 32'd3);
    measure(0, hi, per);
    chk("R11 channel 0 period kept", 32'(per), 32'd10);
    chk("R11 channel 0 high kept", 32'(hi), 32'd5);
  endtask

  task automatic t_reserved;
    logic [31:0] v;
    int hi, per;
    wr(7'h20, 32'hF);
    rd(7'h20, v); chk("R1 unbuilt slot reads zero", v, 32'h0);
    rd(7'h40, v); chk("R1 unbuilt slot sets no flag", v, 32'h0);
    wr(7'h40, 32'hFFFF_FFFF);
    rd(7'h40, v); chk("R1 status ignores writes", v, 32'h0);
    measure(0, hi, per);
    chk("R1 channel 0 unaffected", 32'(hi), 32'd5);
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_ctrl_flag();
    t_direct_commit();
    t_waveform();
    t_autoload();
    t_force_load();
    t_graceful();
    t_stop_now();
    t_second_channel();
    t_reserved();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule